// File: doc/BRIEF.md
# Byte program and page erase controller

This block sits between a processor's external-data write port and an on-chip non-volatile byte array. A small control register holds two bits: a store-enable bit that redirects processor data-space writes away from data RAM and into the array, and an erase-select bit that turns such a write into a page erase. Every redirected write is an attempt. The block reports each attempt to a separate key lock unit and only acts when that unit grants it in the same cycle.

A granted byte program can only clear bits: the stored byte becomes the old byte ANDed with the written data. A granted erase sets every byte of the 512-byte page that holds the written address to 0xFF. Any offset inside the page selects it. After a granted operation the block raises a stall output for a fixed number of cycles, set by parameter, so software never has to poll for completion. While the stall is high, new writes, register writes and array reads are all held off. The page count is a parameter. The default builds four pages (2 KB). The full 8 KB array with a 13-bit address (4-bit page index, 9-bit offset) uses PG_IDX_W = 4.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. A register write keeps bit 0 (store enable) and bit 1 (erase select), and bits 7..2 always read 0.
- R2: With store enable at 0, a processor write raises ram_wr in the same cycle, gives no key_attempt and leaves the array unchanged.
- R3: With store enable at 1 and stall low, a processor write raises key_attempt in the same cycle and never ram_wr.
- R4: A granted write with erase select at 0 stores old AND new data at the addressed byte and changes no other byte.
- R5: A granted write with both bits at 1 sets all 512 bytes of the addressed page to 0xFF and leaves the other pages unchanged.
- R6: An attempt made while key_grant is low changes no byte and does not raise stall.
- R7: A granted program raises stall from the next cycle for exactly PROG_CYC cycles. A granted erase does the same for exactly ERASE_CYC cycles.
- R8: Store enable stays set after an operation completes and clears only when software writes it to 0.
- R9: While stall is high, rd_data reads 0x00 and processor writes and register writes are ignored: no key_attempt, no ram_wr, no state change.
- R10: Erase select alone, with store enable at 0, still routes writes to data RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor data-space write strobe |
| cpu_addr | input | PG_IDX_W+PG_OFS_W | Processor write/read address |
| cpu_wdata | input | 8 | Processor write data |
| rd_data | output | 8 | Array byte at cpu_addr, 0x00 while stalled |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| key_grant | input | 1 | Grant from the key lock unit |
| key_attempt | output | 1 | Pulse on every attempted array operation |
| ram_wr | output | 1 | Write routed to data RAM |
| stall | output | 1 | Processor stall during a timed operation |

## Verification
The hardest case to reach from the ports is a write or register write that arrives while a timed operation is still running. The processor would normally be frozen then, so the bench drives both strobes on purpose in the middle of a stall. It then reads back the register and the array to show that nothing moved. Erase isolation is also hard to show, because it needs known contents in every page. The bench first erases each page through a different in-page offset, programs bytes at page edges, erases one page, and sweeps the whole address space against its model.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } nvm_op_e;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BIT_WEN = 0;
  localparam int unsigned BIT_ERS = 1;
endpackage

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              wen,
  output logic              ers
);
  logic wen_d, ers_d;

  always_comb begin
    wen_d = wen;
    ers_d = ers;
    if (wr_en) begin
      wen_d = wdata[BIT_WEN];
      ers_d = wdata[BIT_ERS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
      ers <= 1'b0;
    end else begin
      wen <= wen_d;
      ers <= ers_d;
    end
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    wen,
  input  logic    ers,
  input  logic    grant,
  output logic    attempt,
  output logic    route_ram,
  output nvm_op_e op,
  output logic    busy
);
  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;

  always_comb begin
    attempt   = req & wen & ~busy;
    route_ram = req & ~wen & ~busy;
    op        = OP_NONE;
    if (attempt && grant) op = ers ? OP_ERASE : OP_PROG;
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (op == OP_PROG) begin
      cnt_d  = PROG_LD;
      busy_d = 1'b1;
    end else if (op == OP_ERASE) begin
      cnt_d  = ERASE_LD;
      busy_d = 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int unsigned PG_IDX_W = 2,
  parameter int unsigned PG_OFS_W = 9
) (
  input  logic                       clk,
  input  nvm_op_e                    op,
  input  logic [PG_IDX_W+PG_OFS_W-1:0] addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata
);
  localparam int unsigned AW    = PG_IDX_W + PG_OFS_W;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PG_SZ = 1 << PG_OFS_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PG_IDX_W-1:0] page;

  assign page  = addr[AW-1:PG_OFS_W];
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (op == OP_PROG) begin
      mem[addr] <= mem[addr] & wdata;
    end else if (op == OP_ERASE) begin
      for (int i = 0; i < PG_SZ; i++) begin
        mem[{page, PG_OFS_W'(i)}] <= '1;
      end
    end
  end
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned PG_IDX_W  = 2,
  parameter int unsigned PG_OFS_W  = 9,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned ERASE_CYC = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_wr,
  input  logic [PG_IDX_W+PG_OFS_W-1:0] cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  output logic [7:0]                   rd_data,
  input  logic                         ctl_wr,
  input  logic [7:0]                   ctl_wdata,
  output logic [7:0]                   ctl_rdata,
  input  logic                         key_grant,
  output logic                         key_attempt,
  output logic                         ram_wr,
  output logic                         stall
);
  logic    wen, ers, busy;
  nvm_op_e op;
  logic [DATA_W-1:0] arr_rdata;

  nvm_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl_wr & ~busy),
    .wdata (ctl_wdata),
    .wen   (wen),
    .ers   (ers)
  );

  nvm_seq #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (cpu_wr),
    .wen       (wen),
    .ers       (ers),
    .grant     (key_grant),
    .attempt   (key_attempt),
    .route_ram (ram_wr),
    .op        (op),
    .busy      (busy)
  );

  nvm_array #(
    .PG_IDX_W (PG_IDX_W),
    .PG_OFS_W (PG_OFS_W)
  ) u_arr (
    .clk   (clk),
    .op    (op),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .rdata (arr_rdata)
  );

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[BIT_WEN] = wen;
    ctl_rdata[BIT_ERS] = ers;
    rd_data            = busy ? '0 : arr_rdata;
    stall              = busy;
  end
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_attempt,
  input logic       key_grant,
  input logic       ram_wr,
  input logic       stall,
  input logic [7:0] rd_data,
  input logic [7:0] ctl_rdata
);
  // R3
  attempt_not_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_attempt |-> !ram_wr);

  // R7
  grant_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_attempt && key_grant) |=> stall);

  // R7
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(key_attempt && key_grant));

  // R6
  deny_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_attempt && !key_grant) |=> !stall);

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!key_attempt && !ram_wr && rd_data == 8'h00));

  // R8
  wen_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> ctl_rdata[0]);
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .key_attempt (key_attempt),
  .key_grant   (key_grant),
  .ram_wr      (ram_wr),
  .stall       (stall),
  .rd_data     (rd_data),
  .ctl_rdata   (ctl_rdata)
);

// File: tb/nvm_prog_ctrl_test.sv
module nvm_prog_ctrl_test;
  localparam int PER   = 10;
  localparam int IDX_W = 2;
  localparam int OFS_W = 9;
  localparam int AW    = IDX_W + OFS_W;
  localparam int DEPTH = 1 << AW;
  localparam int PG    = 1 << OFS_W;
  localparam int PCYC  = 4;
  localparam int ECYC  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    rd_data;
  logic          ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic          key_grant = 1'b0;
  logic          key_attempt, ram_wr, stall;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  string tag = "R1";

  int m_mem [DEPTH];
  int m_cnt = 0;
  int m_ctl = 0;

  nvm_prog_ctrl #(.PG_IDX_W(IDX_W), .PG_OFS_W(OFS_W), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .key_grant(key_grant), .key_attempt(key_attempt), .ram_wr(ram_wr), .stall(stall));

  always #(PER/2) clk = ~clk;

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = -1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0;
      m_ctl = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else begin
      int old_ctl;
      old_ctl = m_ctl;
      if (ctl_wr) m_ctl = ctl_wdata & 3;
      if (cpu_wr && old_ctl[0] && key_grant) begin
        if (old_ctl[1]) begin
          int base;
          base = (int'(cpu_addr) / PG) * PG;
          for (int i = 0; i < PG; i++) m_mem[base + i] = 255;
          m_cnt = ECYC;
        end else begin
          if (m_mem[cpu_addr] >= 0) m_mem[cpu_addr] = m_mem[cpu_addr] & int'(cpu_wdata);
          m_cnt = PCYC;
        end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #(PER/4);
    begin
      bit busy;
      int exp_rd;
      busy = (m_cnt > 0);
      chk(stall === busy, "R7", "stall", int'(stall), int'(busy));
      chk(ctl_rdata === 8'(m_ctl), "R1", "ctl_rdata", int'(ctl_rdata), m_ctl);
      if (rst_n) begin
        chk(ram_wr === (cpu_wr && !m_ctl[0] && !busy), "R2", "ram_wr", int'(ram_wr),
            int'(cpu_wr && !m_ctl[0] && !busy));
        chk(key_attempt === (cpu_wr && m_ctl[0] && !busy), "R3", "key_attempt",
            int'(key_attempt), int'(cpu_wr && m_ctl[0] && !busy));
        exp_rd = busy ? 0 : m_mem[cpu_addr];
        if (exp_rd >= 0) chk(rd_data === 8'(exp_rd), tag, "rd_data", int'(rd_data), exp_rd);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_wr = 1'b0;
      ctl_wr = 1'b0;
    end
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v; cpu_wr = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wmem(input int a, input logic [7:0] d, input bit g);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = d; key_grant = g;
    @(negedge clk);
    cpu_wr = 1'b0; key_grant = 1'b0;
    while (m_cnt > 0) @(negedge clk);
  endtask

  task automatic sweep();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      cpu_addr = AW'(a);
    end
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    wctl(8'hFF);                      // R1: upper bits drop
    idle(1);
    wctl(8'h00);

    tag = "R5";                       // erase every page via different offsets
    wctl(8'h03);
    wmem(0 * PG + 5,   8'h00, 1'b1);
    wmem(1 * PG + 0,   8'h00, 1'b1);
    wmem(2 * PG + 511, 8'h00, 1'b1);
    wmem(3 * PG + 256, 8'h00, 1'b1);

    tag = "R4";
    wctl(8'h01);
    wmem(0,          8'hA5, 1'b1);
    wmem(0,          8'h3C, 1'b1);    // AND: 0x24
    wmem(PG - 1,     8'h0F, 1'b1);
    wmem(PG,         8'hF0, 1'b1);
    wmem(3 * PG + 7, 8'h81, 1'b1);
    wmem(2 * PG + 9, 8'h55, 1'b1);

    tag = "R8";
    chk(ctl_rdata === 8'h01, "R8", "wen after op", int'(ctl_rdata), 1);

    tag = "R6";
    wmem(1 * PG + 3, 8'h00, 1'b0);
    wmem(0,          8'h00, 1'b0);

    tag = "R2";
    wctl(8'h00);
    wmem(0,          8'h00, 1'b1);
    wmem(PG + 3,     8'h00, 1'b1);

    tag = "R10";
    wctl(8'h02);
    wmem(2 * PG + 9, 8'h00, 1'b1);

    tag = "R9";
    wctl(8'h01);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = AW'(PG + 20); cpu_wdata = 8'h0F; key_grant = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = AW'(PG + 21); cpu_wdata = 8'h00;
    ctl_wr = 1'b1; ctl_wdata = 8'h03;
    @(negedge clk);
    cpu_addr = AW'(PG + 20);
    ctl_wr = 1'b0;
    idle(PCYC);
    cpu_wr = 1'b0; key_grant = 1'b0;
    idle(2);
    chk(ctl_rdata === 8'h01, "R9", "ctl after stalled write", int'(ctl_rdata), 1);

    tag = "R5";                       // erase page 0 only, then check all pages
    wctl(8'h03);
    wmem(100, 8'h00, 1'b1);
    wctl(8'h00);
    sweep();

    tag = "R8";
    wctl(8'h00);
    idle(2);
    chk(ctl_rdata === 8'h00, "R8", "wen cleared by software", int'(ctl_rdata), 0);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R7 act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule